// File: doc/BRIEF.md
# Session-Loaded Shift Table Bank

This block keeps a small library of one-dimensional tables of circulant shift values, one per code, as hardwired constants. Before a decoding session starts, a select input names one of the codes and a load strobe copies that code's table into a working register. For the rest of the session the block presents only the register's contents on a wide output bus. A change of the select input alone does not change the bus, so the constant library is only consulted again when a later session loads a different code.

The tables are built at elaboration time. Each bus bit that holds the same value in every code of the library is merged into a single tied-off constant and needs no flip-flop. Only the bits that differ between codes go through the select multiplexer into the working register. The bus therefore mixes fixed logic levels with register outputs. The number of register bits is worked out from the tables and is not a free parameter.

Top module: `shift_table_bank`

## Requirements
- R1: The library holds NUM_CODES codes (default 4), chosen by a select input of $clog2(NUM_CODES) bits. Each table has ENTRIES entries (default 19) of ENTRY_W bits (default 8), for a 152-bit bus. Entry w sits at bus bits [w*ENTRY_W +: ENTRY_W]. For code c, entry w equals PRIM^w mod PRIME (defaults 3 and 31). The one exception is entry t_c = (1 + c*(ENTRIES/NUM_CODES)) mod ENTRIES, which equals PRIM^(w+c+1) mod PRIME.
- R2: When the load strobe is high at a rising clock edge, the bus equals the full table of the selected code from that edge on.
- R3: When the load strobe is low at a rising edge, the bus keeps its value, whatever the select input does.
- R4: Every bus bit whose value is the same in all library tables is driven to that value at all times, including during and just after reset.
- R5: Reset (active low, asynchronous) clears every register-backed bus bit to 0 and clears the ready flag.
- R6: The ready flag rises at the rising edge that captures the first load after reset. It then stays high through later loads until the next reset.
- R7: Loads held high on consecutive edges take a new code on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| codeSel | input | $clog2(NUM_CODES) | Index of the code to load |
| loadStb | input | 1 | Load the selected code at the next rising edge |
| shiftBus | output | ENTRIES*ENTRY_W | All shift values of the active code |
| ready | output | 1 | A code has been loaded since reset |

## Verification
A load has one register stage: the table sampled at a rising edge is visible on the bus right after that edge, and ready rises at the same edge. The bench changes inputs on falling edges and compares the bus and ready at the following falling edge, one half period after the edge that produced them. Reset acts without a clock, so its results are compared a single time unit after reset is asserted. The expected tables and the mask of shared bits are rebuilt in the bench from the formula in R1. Every comparison of the bus also confirms that the shared bits match the constants of R4.

// File: rtl/shift_table_bank_pkg.sv
package shift_table_bank_pkg;

  typedef struct packed {
    logic capture;
  } bankCtl_t;

  function automatic int powMod(input int base, input int expo, input int prime);
    int acc;
    acc = 1;
    for (int i = 0; i < expo; i++) acc = (acc * base) % prime;
    return acc;
  endfunction

  function automatic int tweakIdx(input int code, input int entries, input int numCodes);
    return (1 + code * (entries / numCodes)) % entries;
  endfunction

  function automatic int entryVal(input int code, input int w, input int entries,
                                  input int numCodes, input int prime, input int prim);
    if (w == tweakIdx(code, entries, numCodes))
      return powMod(prim, w + code + 1, prime);
    return powMod(prim, w, prime);
  endfunction

endpackage

// File: rtl/shift_table_ctrl.sv
module shift_table_ctrl
  import shift_table_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     loadStb,
  output bankCtl_t ctl,
  output logic     ready
);

  assign ctl.capture = loadStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ready <= 1'b0;
    else if (loadStb) ready <= 1'b1;
  end

  AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> ready); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready); // R6
  AST_READY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(loadStb)); // R6

endmodule

// File: rtl/shift_table_datapath.sv
module shift_table_datapath
  import shift_table_bank_pkg::*;
#(
  parameter int NUM_CODES = 4,
  parameter int ENTRIES   = 19,
  parameter int ENTRY_W   = 8,
  parameter int PRIME     = 31,
  parameter int PRIM      = 3,
  localparam int SEL_W    = $clog2(NUM_CODES),
  localparam int TABLE_W  = ENTRIES * ENTRY_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  bankCtl_t           ctl,
  input  logic [SEL_W-1:0]   codeSel,
  output logic [TABLE_W-1:0] tableOut
);

  function automatic logic [NUM_CODES*TABLE_W-1:0] buildLib();
    logic [NUM_CODES*TABLE_W-1:0] lib;
    lib = '0;
    for (int c = 0; c < NUM_CODES; c++)
      for (int w = 0; w < ENTRIES; w++)
        lib[c*TABLE_W + w*ENTRY_W +: ENTRY_W] =
          ENTRY_W'(entryVal(c, w, ENTRIES, NUM_CODES, PRIME, PRIM));
    return lib;
  endfunction

  localparam logic [NUM_CODES*TABLE_W-1:0] LIB = buildLib();

  function automatic logic [TABLE_W-1:0] buildVaryMask();
    logic [TABLE_W-1:0] m;
    m = '0;
    for (int i = 0; i < TABLE_W; i++)
      for (int c = 1; c < NUM_CODES; c++)
        if (LIB[c*TABLE_W + i] != LIB[i]) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [TABLE_W-1:0] VARY_MASK = buildVaryMask();
  localparam logic [TABLE_W-1:0] BASE_TBL  = LIB[TABLE_W-1:0];

  function automatic int rankOf(input int pos);
    int n;
    n = 0;
    for (int i = 0; i < pos; i++) if (VARY_MASK[i]) n++;
    return n;
  endfunction

  function automatic int posOf(input int k);
    int n;
    int p;
    n = 0;
    p = 0;
    for (int i = 0; i < TABLE_W; i++)
      if (VARY_MASK[i]) begin
        if (n == k) p = i;
        n++;
      end
    return p;
  endfunction

  localparam int VARY_W   = rankOf(TABLE_W);
  localparam int VARY_W_R = (VARY_W > 0) ? VARY_W : 1;

  logic [VARY_W_R-1:0] varyNext;
  logic [VARY_W_R-1:0] varyQ;
  logic [TABLE_W-1:0]  pickedTable;

  assign pickedTable = LIB[int'(codeSel)*TABLE_W +: TABLE_W];

  for (genvar k = 0; k < VARY_W_R; k++) begin : g_mux
    if (k < VARY_W) begin : g_live
      localparam int POS = posOf(k);
      assign varyNext[k] = LIB[int'(codeSel)*TABLE_W + POS];
    end else begin : g_pad
      assign varyNext[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) varyQ <= '0;
    else if (ctl.capture) varyQ <= varyNext;
  end

  for (genvar i = 0; i < TABLE_W; i++) begin : g_bus
    if (VARY_MASK[i]) begin : g_reg
      assign tableOut[i] = varyQ[rankOf(i)];
    end else begin : g_tie
      assign tableOut[i] = BASE_TBL[i];
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> tableOut == $past(pickedTable)); // R2
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(tableOut)); // R3
  AST_SHARED_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    ((tableOut ^ BASE_TBL) & ~VARY_MASK) == '0); // R4

endmodule

// File: rtl/shift_table_bank.sv
module shift_table_bank
  import shift_table_bank_pkg::*;
#(
  parameter int NUM_CODES = 4,
  parameter int ENTRIES   = 19,
  parameter int ENTRY_W   = 8,
  parameter int PRIME     = 31,
  parameter int PRIM      = 3,
  localparam int SEL_W    = $clog2(NUM_CODES),
  localparam int TABLE_W  = ENTRIES * ENTRY_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   codeSel,
  input  logic               loadStb,
  output logic [TABLE_W-1:0] shiftBus,
  output logic               ready
);

  bankCtl_t ctl;

  shift_table_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadStb (loadStb),
    .ctl     (ctl),
    .ready   (ready)
  );

  shift_table_datapath #(
    .NUM_CODES (NUM_CODES),
    .ENTRIES   (ENTRIES),
    .ENTRY_W   (ENTRY_W),
    .PRIME     (PRIME),
    .PRIM      (PRIM)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .codeSel  (codeSel),
    .tableOut (shiftBus)
  );

endmodule

// File: tb/shift_table_bank_tb_top.sv
module shift_table_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC   = 4;
  localparam int NE   = 19;
  localparam int EW   = 8;
  localparam int PR   = 31;
  localparam int GEN  = 3;
  localparam int SW   = 2;
  localparam int TW   = NE * EW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [SW-1:0] codeSel;
  logic          loadStb;
  logic [TW-1:0] shiftBus;
  logic          ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_table_bank #(
    .NUM_CODES (NC), .ENTRIES (NE), .ENTRY_W (EW), .PRIME (PR), .PRIM (GEN)
  ) dut_i (
    .clk (clk), .rstN (rstN), .codeSel (codeSel),
    .loadStb (loadStb), .shiftBus (shiftBus), .ready (ready)
  );

  // R1: expected table rebuilt from the stated formula
  function automatic int expPow(input int e);
    int v = 1;
    for (int i = 0; i < e; i++) v = (v * GEN) % PR;
    return v;
  endfunction

  function automatic logic [TW-1:0] expTable(input int c);
    logic [TW-1:0] t = '0;
    int special = (1 + c * (NE / NC)) % NE;
    for (int w = 0; w < NE; w++) begin
      int v = (w == special) ? expPow(w + c + 1) : expPow(w);
      t[w*EW +: EW] = EW'(v);
    end
    return t;
  endfunction

  function automatic logic [TW-1:0] sharedMask();
    logic [TW-1:0] m = '1;
    for (int c = 1; c < NC; c++) m &= ~(expTable(c) ^ expTable(0));
    return m;
  endfunction

  task automatic checkBus(input string req, input logic [TW-1:0] exp);
    checks++;
    if (shiftBus !== exp) begin
      errors++;
      $display("FAIL %s bus actual %h expected %h", req, shiftBus, exp);
    end
    checks++;
    if (((shiftBus ^ expTable(0)) & sharedMask()) != '0) begin
      errors++;
      $display("FAIL R4 shared bits actual %h expected %h",
               shiftBus & sharedMask(), expTable(0) & sharedMask());
    end
  endtask

  task automatic checkReady(input string req, input logic exp);
    checks++;
    if (ready !== exp) begin
      errors++;
      $display("FAIL %s ready actual %b expected %b", req, ready, exp);
    end
  endtask

  task automatic loadCode(input int c);
    codeSel = SW'(c);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0; loadStb = 1'b0; codeSel = '0;
    repeat (3) @(negedge clk);
    checkBus("R5 reset clears register bits", expTable(0) & sharedMask());
    checkReady("R5 reset clears ready", 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkBus("R3 no load after reset", expTable(0) & sharedMask());
    checkReady("R6 ready waits for load", 1'b0);
  endtask

  task automatic tLoadEach();
    for (int c = 0; c < NC; c++) begin
      loadCode(c);
      checkBus($sformatf("R2 load code %0d", c), expTable(c));
      checkReady("R6 ready after load", 1'b1);
    end
  endtask

  task automatic tHoldNoLoad();
    loadCode(2);
    for (int s = 0; s < NC; s++) begin
      codeSel = SW'(3 - s);
      @(negedge clk);
      checkBus("R3 select change without load", expTable(2));
    end
    checkReady("R6 ready sticky", 1'b1);
  endtask

  task automatic tBackToBack();
    int order[4] = '{1, 3, 0, 2};
    foreach (order[i]) begin
      codeSel = SW'(order[i]);
      loadStb = 1'b1;
      @(negedge clk);
      checkBus("R7 consecutive loads", expTable(order[i]));
    end
    loadStb = 1'b0;
    @(negedge clk);
    checkBus("R3 hold after burst", expTable(2));
  endtask

  task automatic tMidReset();
    loadCode(3);
    rstN = 1'b0;
    #1;
    checkBus("R5 async reset mid-session", expTable(0) & sharedMask());
    checkReady("R5 ready cleared", 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    codeSel = 2'd1;
    @(negedge clk);
    checkBus("R3 no load after second reset", expTable(0) & sharedMask());
    checkReady("R6 ready low until load", 1'b0);
    loadCode(1);
    checkBus("R2 load after reset", expTable(1));
    checkReady("R6 ready after reload", 1'b1);
  endtask

  initial begin
    tReset();
    tLoadEach();
    tHoldNoLoad();
    tBackToBack();
    tMidReset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule